// File: doc/BRIEF.md
# Accumulator ALU With Status Flags

This block is the arithmetic and logic core of a small 8-bit datapath. An accumulator register is always the first operand. A second register holds the other operand; it is loaded from the operand bus and cannot be read back. One strobe runs an operation chosen by a 4-bit code: add, add with carry, subtract, subtract with borrow, AND, XOR, OR, compare, increment and decrement. The result is written back to the accumulator.

Two further codes increment or decrement the hidden operand register's value on behalf of some register outside this block. Their result appears on a separate result bus, and the accumulator is left alone. Every operation updates a status byte that holds sign, zero, nibble carry, even parity and carry. Increment and decrement keep the carry bit as it was. All outputs are registered and change one clock edge after the strobe that causes them.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the hidden register and `res_o` become 0, and `flags_o` becomes 8'h02.
- R2: `acc_ld_i` without `exec_i` copies `opnd_i` into the accumulator at the edge. `tmp_ld_i` copies `opnd_i` into the hidden register. Loading only the hidden register changes none of the outputs. An operation always uses the hidden value held before the edge.
- R3: Op 0 (add) and op 1 (add plus the current carry) write the low 8 bits of the sum to the accumulator. CY takes the carry out of the top bit.
- R4: Op 2 (subtract) and op 3 (subtract with the current carry as borrow) write accumulator minus operand (minus borrow). CY is set exactly when a borrow occurred.
- R5: AC is the carry from bit 3 into bit 4 of the addition the unit performs. For subtraction that addition is accumulator + inverted operand + inverted borrow. Increment adds 1. Decrement adds all-ones.
- R6: After every operation, S equals bit 7 of the result, Z is set when the result is zero, and P is set when the result has an even number of one bits.
- R7: Op 4 (AND), op 5 (XOR) and op 6 (OR) write the bitwise result to the accumulator and clear both CY and AC.
- R8: Op 7 (compare) sets the flags exactly as subtract would, and leaves the accumulator unchanged.
- R9: Op 8 increments and op 9 decrements the accumulator modulo 256. CY keeps its old value.
- R10: Op 10 increments and op 11 decrements the hidden register's value onto `res_o`. The accumulator, the hidden register and CY are unchanged. S, Z, AC and P follow the result.
- R11: When `exec_i` is high, `acc_ld_i` is ignored in that cycle.
- R12: The flag byte has S in bit 7, Z in bit 6, AC in bit 4, P in bit 2 and CY in bit 0. Bits 5 and 3 read 0 and bit 1 reads 1.
- R13: `res_o` shows the 8-bit result of every executed operation, compare included, and holds between operations. Codes 12 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| exec_i | input | 1 | Run the operation in op_i |
| tmp_ld_i | input | 1 | Load opnd_i into the hidden operand register |
| acc_ld_i | input | 1 | Load opnd_i into the accumulator |
| opnd_i | input | DATA_W | Operand bus |
| acc_o | output | DATA_W | Accumulator |
| flags_o | output | 8 | Status byte |
| res_o | output | DATA_W | Result of the last operation |

## Verification
The bench builds the block with its defaults, DATA_W of 8 and a 4-bit nibble boundary. With those values, random bytes reach every sum and borrow, the all-ones and zero wrap of increment and decrement, and both parity values. Fixed-seed random strobes also hit the chained-carry cases for add with carry and subtract with borrow. They overlap an operation with an accumulator load and a hidden-register load in the same cycle. Directed cases pin the exact flag byte for a wrap to zero and for a borrow out of zero.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_AND = 4'd4, OP_XOR = 4'd5, OP_OR  = 4'd6, OP_CMP = 4'd7,
    OP_INA = 4'd8, OP_DCA = 4'd9, OP_INX = 4'd10, OP_DCX = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {LG_AND = 2'd0, LG_XOR = 2'd1, LG_OR = 2'd2} lg_sel_e;

  typedef struct packed {
    logic    valid;
    logic    wr_acc;
    logic    unary;
    logic    on_tmp;
    logic    dec;
    logic    sub;
    logic    use_cin;
    logic    is_logic;
    logic    keep_cy;
    lg_sel_e lsel;
  } alu_ctl_t;

  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_AC = 4;
  localparam int FB_P  = 2;
  localparam int FB_CY = 0;
  localparam logic [7:0] FLAG_FIXED_ONE = 8'h02;
endpackage

// File: rtl/acc_alu_dec.sv
`timescale 1ns/1ps
module acc_alu_dec
  import acc_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    ctl_o.lsel = LG_AND;
    case (op_i)
      OP_ADD: begin ctl_o.valid = 1'b1; ctl_o.wr_acc = 1'b1; end
      OP_ADC: begin ctl_o.valid = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.use_cin = 1'b1; end
      OP_SUB: begin ctl_o.valid = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.sub = 1'b1; end
      OP_SBB: begin ctl_o.valid = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.sub = 1'b1; ctl_o.use_cin = 1'b1; end
      OP_AND: begin ctl_o.valid = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.is_logic = 1'b1; ctl_o.lsel = LG_AND; end
      OP_XOR: begin ctl_o.valid = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.is_logic = 1'b1; ctl_o.lsel = LG_XOR; end
      OP_OR:  begin ctl_o.valid = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.is_logic = 1'b1; ctl_o.lsel = LG_OR; end
      OP_CMP: begin ctl_o.valid = 1'b1; ctl_o.sub = 1'b1; end
      OP_INA: begin ctl_o.valid = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.unary = 1'b1; ctl_o.keep_cy = 1'b1; end
      OP_DCA: begin ctl_o.valid = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.unary = 1'b1; ctl_o.dec = 1'b1; ctl_o.keep_cy = 1'b1; end
      OP_INX: begin ctl_o.valid = 1'b1; ctl_o.unary = 1'b1; ctl_o.on_tmp = 1'b1; ctl_o.keep_cy = 1'b1; end
      OP_DCX: begin ctl_o.valid = 1'b1; ctl_o.unary = 1'b1; ctl_o.on_tmp = 1'b1; ctl_o.dec = 1'b1; ctl_o.keep_cy = 1'b1; end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_arith.sv
`timescale 1ns/1ps
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  alu_ctl_t            ctl_i,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic [DATA_W-1:0]   tmp_i,
  input  logic                cy_i,
  output logic [DATA_W-1:0]   res_o,
  output logic                cy_o,
  output logic                hc_o
);
  logic [DATA_W-1:0] op_a, op_b, lg_res;
  logic              cin;
  logic [DATA_W:0]   full_sum;
  logic [NIB_W:0]    low_sum;

  always_comb begin
    if (ctl_i.unary) begin
      op_a = ctl_i.on_tmp ? tmp_i : acc_i;
      op_b = ctl_i.dec ? {DATA_W{1'b1}} : '0;
      cin  = ~ctl_i.dec;
    end else begin
      op_a = acc_i;
      op_b = ctl_i.sub ? ~tmp_i : tmp_i;
      cin  = ctl_i.sub ? ~(ctl_i.use_cin & cy_i) : (ctl_i.use_cin & cy_i);
    end
  end

  assign full_sum = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, cin};
  assign low_sum  = {1'b0, op_a[NIB_W-1:0]} + {1'b0, op_b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};

  always_comb begin
    case (ctl_i.lsel)
      LG_XOR:  lg_res = acc_i ^ tmp_i;
      LG_OR:   lg_res = acc_i | tmp_i;
      default: lg_res = acc_i & tmp_i;
    endcase
  end

  always_comb begin
    if (ctl_i.is_logic) begin
      res_o = lg_res;
      cy_o  = 1'b0;
      hc_o  = 1'b0;
    end else begin
      res_o = full_sum[DATA_W-1:0];
      cy_o  = ctl_i.sub ? ~full_sum[DATA_W] : full_sum[DATA_W];
      hc_o  = low_sum[NIB_W];
    end
  end
endmodule

// File: rtl/acc_alu_flags.sv
`timescale 1ns/1ps
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              cy_i,
  input  logic              hc_i,
  input  logic              keep_cy_i,
  input  logic              cy_old_i,
  output logic [7:0]        flags_o
);
  logic [7:0] live;

  always_comb begin
    live        = '0;
    live[FB_S]  = res_i[DATA_W-1];
    live[FB_Z]  = (res_i == '0);
    live[FB_AC] = hc_i;
    live[FB_P]  = ~(^res_i);
    live[FB_CY] = keep_cy_i ? cy_old_i : cy_i;
  end

  for (genvar i = 0; i < 8; i++) begin : g_bit
    if (FLAG_FIXED_ONE[i]) begin : g_one
      assign flags_o[i] = 1'b1;
    end else begin : g_live
      assign flags_o[i] = live[i];
    end
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic              exec_i,
  input  logic              tmp_ld_i,
  input  logic              acc_ld_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [7:0]        flags_o,
  output logic [DATA_W-1:0] res_o
);
  alu_ctl_t          ctl;
  logic [DATA_W-1:0] acc_q, tmp_q, res_q, res_d;
  logic [7:0]        flags_q, flags_d;
  logic              cy_d, hc_d;

  acc_alu_dec u_dec (.op_i(op_i), .ctl_o(ctl));

  acc_alu_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
    .ctl_i(ctl), .acc_i(acc_q), .tmp_i(tmp_q), .cy_i(flags_q[FB_CY]),
    .res_o(res_d), .cy_o(cy_d), .hc_o(hc_d)
  );

  acc_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .res_i(res_d), .cy_i(cy_d), .hc_i(hc_d), .keep_cy_i(ctl.keep_cy),
    .cy_old_i(flags_q[FB_CY]), .flags_o(flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      tmp_q   <= '0;
      res_q   <= '0;
      flags_q <= FLAG_FIXED_ONE;
    end else begin
      if (tmp_ld_i) tmp_q <= opnd_i;
      if (exec_i) begin
        if (ctl.valid) begin
          flags_q <= flags_d;
          res_q   <= res_d;
          if (ctl.wr_acc) acc_q <= res_d;
        end
      end else if (acc_ld_i) begin
        acc_q <= opnd_i;
      end
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flags_q;
  assign res_o   = res_q;
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic              exec_i,
  input logic              acc_ld_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [7:0]        flags_o,
  input logic [DATA_W-1:0] res_o
);
  // R8
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 4'd7) |=> $stable(acc_o));

  // R10
  side_incdec_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && (op_i == 4'd10 || op_i == 4'd11)) |=> ($stable(acc_o) && flags_o[0] == $past(flags_o[0])));

  // R9
  acc_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 4'd8) |=> (acc_o == DATA_W'($past(acc_o) + 1'b1)));

  // R7
  logic_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6)) |=> (flags_o[0] == 1'b0 && flags_o[4] == 1'b0));

  // R6
  result_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i < 4'd12) |=> (flags_o[7] == res_o[DATA_W-1] && flags_o[6] == (res_o == '0) && flags_o[2] == ~(^res_o)));

  // R2
  idle_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (!exec_i && !acc_ld_i) |=> $stable(acc_o));

  // R13
  idle_res_chk: assert property (@(posedge clk) disable iff (rst)
    (!exec_i || op_i >= 4'd12) |=> ($stable(res_o) && $stable(flags_o)));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .exec_i(exec_i), .acc_ld_i(acc_ld_i),
  .acc_o(acc_o), .flags_o(flags_o), .res_o(res_o)
);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = '0;
  logic       exec_i = 1'b0, tmp_ld_i = 1'b0, acc_ld_i = 1'b0;
  logic [7:0] opnd_i = '0;
  logic [7:0] acc_o, flags_o, res_o;

  int total = 0;
  int bad   = 0;

  int m_acc = 0, m_tmp = 0, m_res = 0;
  logic [7:0] m_flags = 8'h02;

  always #2 clk = ~clk;

  acc_alu u0 (.clk(clk), .rst(rst), .op_i(op_i), .exec_i(exec_i), .tmp_ld_i(tmp_ld_i),
              .acc_ld_i(acc_ld_i), .opnd_i(opnd_i), .acc_o(acc_o), .flags_o(flags_o), .res_o(res_o));

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    if (op <= 1) return "R3";
    if (op <= 3) return "R4";
    if (op <= 6) return "R7";
    if (op == 7) return "R8";
    if (op <= 9) return "R9";
    if (op <= 11) return "R10";
    return "R13";
  endfunction

  // Reference of one operation, straight from the requirements.
  function automatic void ref_op(input int op, input int a, input int t, input bit cy_old,
                                 output int r, output bit c, output bit h, output bit wa);
    int s, bin;
    wa = (op != 7) && (op != 10) && (op != 11);
    c = 1'b0; h = 1'b0; r = 0;
    case (op)
      0, 1: begin
        bin = (op == 1) ? int'(cy_old) : 0;
        s = a + t + bin; r = s & 255; c = (s > 255);
        h = ((a & 15) + (t & 15) + bin) > 15;
      end
      2, 3, 7: begin
        bin = (op == 3) ? int'(cy_old) : 0;
        s = a - t - bin; r = s & 255; c = (s < 0);
        h = ((a & 15) + ((~t) & 15) + (1 - bin)) > 15;
      end
      4: r = a & t;
      5: r = a ^ t;
      6: r = a | t;
      8:  begin r = (a + 1) & 255; h = ((a & 15) == 15); c = cy_old; end
      9:  begin r = (a + 255) & 255; h = ((a & 15) != 0); c = cy_old; end
      10: begin r = (t + 1) & 255; h = ((t & 15) == 15); c = cy_old; end
      11: begin r = (t + 255) & 255; h = ((t & 15) != 0); c = cy_old; end
      default: ;
    endcase
  endfunction

  task automatic step(input bit ex, input bit al, input bit tl, input int op, input int d);
    int r; bit c, h, wa, par;
    @(negedge clk);
    exec_i = ex; acc_ld_i = al; tmp_ld_i = tl; op_i = 4'(op); opnd_i = 8'(d);
    @(posedge clk);
    if (ex) begin
      if (op < 12) begin
        ref_op(op, m_acc, m_tmp, m_flags[0], r, c, h, wa);
        par = ~(^8'(r));
        m_flags = {r[7], (r == 0), 1'b0, h, 1'b0, par, 1'b1, c};
        m_res = r;
        if (wa) m_acc = r;
      end
    end else if (al) m_acc = d;
    if (tl) m_tmp = d;
    #1;
    chk(ex ? op_tag(op) : "R2", "acc", int'(acc_o), m_acc);
    chk(ex ? op_tag(op) : "R13", "flags", int'(flags_o), int'(m_flags));
    chk(ex ? op_tag(op) : "R13", "res", int'(res_o), m_res);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1", "acc", int'(acc_o), 0);
    chk("R1", "flags", int'(flags_o), 8'h02);
    chk("R1", "res", int'(res_o), 0);
    @(negedge clk); rst = 1'b0;

    // R2: hidden load alone changes no output
    step(0, 0, 1, 0, 8'h01);
    step(0, 1, 0, 0, 8'hFF);
    // R12 / R5: FF + 01 -> 00, S0 Z1 AC1 P1 CY1 -> 57
    step(1, 0, 0, 0, 0);
    chk("R12", "flag byte", int'(flags_o), 8'h57);
    // R4 / R5: 00 - 01 -> FF, borrow, no nibble carry -> 87
    step(1, 0, 0, 2, 0);
    chk("R4", "borrow flags", int'(flags_o), 8'h87);
    chk("R5", "sub AC", int'(flags_o[4]), 0);
    // R11: operation wins over accumulator load in the same cycle
    step(1, 1, 0, 0, 8'h55);
    chk("R11", "acc", int'(acc_o), 8'h00);
    // R8: compare equal keeps acc, sets Z
    step(0, 1, 1, 0, 8'h3C);
    step(1, 0, 0, 7, 0);
    chk("R8", "acc kept", int'(acc_o), 8'h3C);
    chk("R6", "Z on equal", int'(flags_o[6]), 1);
    // R9: increment FF wraps to 00 with CY kept at 0
    step(0, 1, 0, 0, 8'hFF);
    step(1, 0, 0, 8, 0);
    chk("R9", "wrap", int'(acc_o), 0);
    chk("R9", "cy kept", int'(flags_o[0]), 0);
    // R10: decrement of hidden 00 onto res
    step(0, 0, 1, 0, 8'h00);
    step(1, 0, 0, 11, 0);
    chk("R10", "res", int'(res_o), 8'hFF);

    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
           int'($urandom_range(0, 15)), int'($urandom_range(0, 255)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule